// File: doc/BRIEF.md
# Mailbox Stack and Scratch Server

This block is a helper engine that sits beside a client core and serves it through two banks of mailbox registers. The client writes data into its own bank of 16 registers. Writing the last register of that bank (index 15) posts a 32-bit command word. The server then decodes the word and does one of four things. It can push several of the client's registers onto a private 64-word stack. It can pop stack words into its return bank. It can store one client register into a 256-word scratch memory. It can fetch one scratch word into a return register.

The server handles one command at a time. When a command is complete, it writes a done token into return register 15. The token carries a sequence tag, the stack depth after the command, an error bit and the echoed operation code. The server also raises a one-cycle `done` pulse. The client reads the return bank through a registered read port. A pop therefore costs the client a round trip: it posts the request, waits for `done`, and then reads the results. A push only needs the data to be in place before the command is posted.

Top module: `mbox_stack_server`

## Requirements
- R1: A write by the client to its register 15 while the server is idle posts a command. Command bits 31:30 select the operation: 00 push, 01 pop, 10 scratch write, 11 scratch read. `busy` is high from the cycle after the post until the command completes.
- R2: A push with count N (bits 3:0) copies client registers 0..N-1 onto the stack in that order, so register N-1 ends on top. The depth grows by N.
- R3: A pop with count N places the top stack word in return register 0, the next in register 1, and so on up to register N-1. The depth shrinks by N.
- R4: A scratch write stores client register n (bits 3:0) at the scratch address in bits 15:8.
- R5: A scratch read places the scratch word at address bits 15:8 into return register n (bits 3:0).
- R6: A push with depth+N > 64, or a pop with N > depth, reports an error. It moves no data, leaves the depth unchanged and leaves the return data registers untouched.
- R7: Completion gives a one-cycle `done` pulse. At the same edge, return register 15 is loaded with the token: bits 31:24 hold the sequence tag (1 for the first command after reset, then +1 per command); bits 22:16 hold the depth after the command; bit 8 holds the error flag; bits 1:0 hold the op code; all other bits are 0. `err` holds the error flag until the next completion.
- R8: A command posted while `busy` is high is ignored. It produces no completion and has no effect on the stack.
- R9: A push or pop with count 0 moves nothing and completes without error.
- R10: After reset, `busy`, `done` and `err` are 0, every return register reads 0, and the stack is empty.
- R11: `ret_rdata` shows the return register selected by `ret_idx` one clock after `ret_idx` is applied.
- R12: The stack and the scratch memory are separate, so scratch writes never alter stacked words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cli_we | input | 1 | Client write strobe into its mailbox bank |
| cli_idx | input | 4 | Client bank register index; 15 posts a command |
| cli_wdata | input | 32 | Data or command word from the client |
| ret_idx | input | 4 | Return bank register selected for reading |
| ret_rdata | output | 32 | Registered return bank read data |
| busy | output | 1 | A command is being processed |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag of the last completed command |

## Verification
Two things can coincide in one cycle: a new command posted by the client, and a command still running in the server. The bench provokes this by posting a pop one cycle after a three-word push, while `busy` is high. It then judges the result at the ports. Exactly one completion must follow, its token must report a push with the grown depth, and a later zero-count command must still report that same depth, which proves the pop never ran. Overflow and underflow are checked at the exact full and empty limits, where the error token must leave both the depth and the earlier return data unchanged.

// File: rtl/mbxsrv_pkg.sv
package mbxsrv_pkg;

  // Operation codes carried in command bits 31:30
  typedef enum logic [1:0] {
    OP_PUSH  = 2'b00,
    OP_POP   = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;

  localparam int CMD_W  = 32;
  localparam int TAG_LO = 24;
  localparam int DEP_LO = 16;
  localparam int ERR_B  = 8;

  function automatic op_e cmd_op(input logic [CMD_W-1:0] w);
    return op_e'(w[31:30]);
  endfunction

  function automatic logic [3:0] cmd_sel(input logic [CMD_W-1:0] w);
    return w[3:0];
  endfunction

  function automatic logic [7:0] cmd_addr(input logic [CMD_W-1:0] w);
    return w[15:8];
  endfunction

endpackage

// File: rtl/mbxsrv_bank.sv
module mbxsrv_bank #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] regs [NREG];

  // One write port, one registered read port; a read in the cycle of a
  // write to the same register returns the old contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) regs[widx] <= wdata;
      rdata <= regs[ridx];
    end
  end

endmodule

// File: rtl/mbxsrv_ram.sv
module mbxsrv_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port shape so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mbxsrv_ctrl.sv
module mbxsrv_ctrl
  import mbxsrv_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int DW        = 32,
  parameter int STK_DEPTH = 64,
  parameter int SCR_DEPTH = 256,
  localparam int IW       = $clog2(NREG),
  localparam int SAW      = $clog2(STK_DEPTH),
  localparam int SPW      = $clog2(STK_DEPTH + 1),
  localparam int XAW      = $clog2(SCR_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           post,
  input  logic [DW-1:0]  post_word,
  // client bank read port
  output logic [IW-1:0]  cb_ridx,
  input  logic [DW-1:0]  cb_rdata,
  // stack memory
  output logic           stk_we,
  output logic [SAW-1:0] stk_waddr,
  output logic [DW-1:0]  stk_wdata,
  output logic [SAW-1:0] stk_raddr,
  input  logic [DW-1:0]  stk_rdata,
  // scratch memory
  output logic           scr_we,
  output logic [XAW-1:0] scr_waddr,
  output logic [DW-1:0]  scr_wdata,
  output logic [XAW-1:0] scr_raddr,
  input  logic [DW-1:0]  scr_rdata,
  // return bank write port
  output logic           rb_we,
  output logic [IW-1:0]  rb_widx,
  output logic [DW-1:0]  rb_wdata,
  // status
  output logic           busy,
  output logic           done,
  output logic           err
);

  st_e            st_q;
  op_e            op_q;
  logic [IW-1:0]  sel_q;
  logic [XAW-1:0] addr_q;
  logic [IW-1:0]  lim_q;
  logic [IW-1:0]  iss_q;
  logic           p1_v;
  logic [IW-1:0]  p1_k;
  logic           bad_q;
  logic [SPW-1:0] sp_q;
  logic [7:0]     seq_q;

  // ---------------- command decode at post time ----------------
  op_e            new_op;
  logic [3:0]     new_n;
  logic [SPW:0]   push_sum;
  logic           new_bad;
  logic [IW-1:0]  new_cnt;
  logic           accept;

  always_comb begin
    new_op   = cmd_op(post_word[CMD_W-1:0]);
    new_n    = cmd_sel(post_word[CMD_W-1:0]);
    push_sum = {1'b0, sp_q} + (SPW+1)'(new_n);
    new_bad  = 1'b0;
    unique case (new_op)
      OP_PUSH: new_bad = (push_sum > (SPW+1)'(STK_DEPTH));
      OP_POP:  new_bad = ((SPW+1)'(new_n) > {1'b0, sp_q});
      default: new_bad = 1'b0;
    endcase
    if (new_op == OP_PUSH || new_op == OP_POP) new_cnt = IW'(new_n);
    else                                       new_cnt = IW'(1);
    accept = post && (st_q == ST_IDLE);
  end

  // ---------------- transfer sequencing ----------------
  logic           issue;
  logic           finish;
  logic [SPW-1:0] sp_next;
  logic [CMD_W-1:0] token;

  always_comb begin
    issue  = (st_q == ST_RUN) && (iss_q < lim_q);
    finish = (st_q == ST_RUN) && (iss_q == lim_q) && !p1_v;
    unique case (op_q)
      OP_PUSH: sp_next = sp_q + SPW'(lim_q);
      OP_POP:  sp_next = sp_q - SPW'(lim_q);
      default: sp_next = sp_q;
    endcase
    token                  = '0;
    token[TAG_LO +: 8]     = seq_q + 8'd1;
    token[DEP_LO +: SPW]   = sp_next;
    token[ERR_B]           = bad_q;
    token[1:0]             = op_q;
  end

  // Source side: addresses presented in the issue cycle, data one cycle later
  always_comb begin
    cb_ridx   = (op_q == OP_WRITE) ? sel_q : iss_q;
    stk_raddr = SAW'(sp_q - SPW'(1) - SPW'(iss_q));
    scr_raddr = addr_q;
  end

  // Destination side: driven from the stage that carries the fetched word
  always_comb begin
    stk_we    = p1_v && (op_q == OP_PUSH);
    stk_waddr = SAW'(sp_q + SPW'(p1_k));
    stk_wdata = cb_rdata;
    scr_we    = p1_v && (op_q == OP_WRITE);
    scr_waddr = addr_q;
    scr_wdata = cb_rdata;
    rb_we     = (p1_v && (op_q == OP_POP || op_q == OP_READ)) || finish;
    if (finish) begin
      rb_widx  = IW'(NREG - 1);
      rb_wdata = DW'(token);
    end else if (op_q == OP_POP) begin
      rb_widx  = p1_k;
      rb_wdata = stk_rdata;
    end else begin
      rb_widx  = sel_q;
      rb_wdata = scr_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_PUSH;
      sel_q  <= '0;
      addr_q <= '0;
      lim_q  <= '0;
      iss_q  <= '0;
      p1_v   <= 1'b0;
      p1_k   <= '0;
      bad_q  <= 1'b0;
      sp_q   <= '0;
      seq_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st_q   <= ST_RUN;
        op_q   <= new_op;
        sel_q  <= IW'(new_n);
        addr_q <= XAW'(cmd_addr(post_word[CMD_W-1:0]));
        lim_q  <= new_bad ? '0 : new_cnt;
        bad_q  <= new_bad;
        iss_q  <= '0;
        p1_v   <= 1'b0;
        busy   <= 1'b1;
      end else if (st_q == ST_RUN) begin
        p1_v <= issue;
        p1_k <= iss_q;
        if (issue) iss_q <= iss_q + IW'(1);
        if (finish) begin
          st_q  <= ST_IDLE;
          sp_q  <= sp_next;
          seq_q <= seq_q + 8'd1;
          busy  <= 1'b0;
          done  <= 1'b1;
          err   <= bad_q;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  // R2 / R6: depth never leaves the stack capacity
  a_r2_depth_in_range: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SPW'(STK_DEPTH));

  // R6: an errored command leaves the depth where it was
  a_r6_err_keeps_depth: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (sp_q == $past(sp_q)));

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: completion and busy never overlap
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: a post during a running command does not disturb the latched command
  a_r8_busy_ignores_post: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && post) |=> (op_q == $past(op_q) && lim_q == $past(lim_q)));

  // R1: memories are only written while a command is running
  a_r1_write_only_running: assert property (@(posedge clk) disable iff (rst)
    (stk_we || scr_we) |-> busy);

endmodule

// File: rtl/mbox_stack_server.sv
module mbox_stack_server #(
  parameter int NREG      = 16,
  parameter int DW        = 32,
  parameter int STK_DEPTH = 64,
  parameter int SCR_DEPTH = 256,
  localparam int IW       = $clog2(NREG),
  localparam int SAW      = $clog2(STK_DEPTH),
  localparam int XAW      = $clog2(SCR_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cli_we,
  input  logic [IW-1:0] cli_idx,
  input  logic [DW-1:0] cli_wdata,
  input  logic [IW-1:0] ret_idx,
  output logic [DW-1:0] ret_rdata,
  output logic          busy,
  output logic          done,
  output logic          err
);

  logic           post;
  logic [IW-1:0]  cb_ridx;
  logic [DW-1:0]  cb_rdata;
  logic           stk_we;
  logic [SAW-1:0] stk_waddr, stk_raddr;
  logic [DW-1:0]  stk_wdata, stk_rdata;
  logic           scr_we;
  logic [XAW-1:0] scr_waddr, scr_raddr;
  logic [DW-1:0]  scr_wdata, scr_rdata;
  logic           rb_we;
  logic [IW-1:0]  rb_widx;
  logic [DW-1:0]  rb_wdata;

  assign post = cli_we && (cli_idx == IW'(NREG - 1));

  mbxsrv_bank #(.NREG(NREG), .DW(DW)) u_cli_bank (
    .clk(clk), .rst(rst),
    .we(cli_we), .widx(cli_idx), .wdata(cli_wdata),
    .ridx(cb_ridx), .rdata(cb_rdata)
  );

  mbxsrv_bank #(.NREG(NREG), .DW(DW)) u_ret_bank (
    .clk(clk), .rst(rst),
    .we(rb_we), .widx(rb_widx), .wdata(rb_wdata),
    .ridx(ret_idx), .rdata(ret_rdata)
  );

  mbxsrv_ram #(.DEPTH(STK_DEPTH), .DW(DW)) u_stack (
    .clk(clk), .we(stk_we), .waddr(stk_waddr), .wdata(stk_wdata),
    .raddr(stk_raddr), .rdata(stk_rdata)
  );

  mbxsrv_ram #(.DEPTH(SCR_DEPTH), .DW(DW)) u_scratch (
    .clk(clk), .we(scr_we), .waddr(scr_waddr), .wdata(scr_wdata),
    .raddr(scr_raddr), .rdata(scr_rdata)
  );

  mbxsrv_ctrl #(
    .NREG(NREG), .DW(DW), .STK_DEPTH(STK_DEPTH), .SCR_DEPTH(SCR_DEPTH)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .post(post), .post_word(cli_wdata),
    .cb_ridx(cb_ridx), .cb_rdata(cb_rdata),
    .stk_we(stk_we), .stk_waddr(stk_waddr), .stk_wdata(stk_wdata),
    .stk_raddr(stk_raddr), .stk_rdata(stk_rdata),
    .scr_we(scr_we), .scr_waddr(scr_waddr), .scr_wdata(scr_wdata),
    .scr_raddr(scr_raddr), .scr_rdata(scr_rdata),
    .rb_we(rb_we), .rb_widx(rb_widx), .rb_wdata(rb_wdata),
    .busy(busy), .done(done), .err(err)
  );

endmodule

// File: tb/mbox_stack_server_tb.sv
module mbox_stack_server_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cli_we = 1'b0;
  logic [3:0]  cli_idx = '0;
  logic [31:0] cli_wdata = '0;
  logic [3:0]  ret_idx = '0;
  logic [31:0] ret_rdata;
  logic        busy, done, err;

  int n_chk = 0;
  int n_fail = 0;
  int ndone = 0;
  int exp_seq = 0;
  bit finished = 1'b0;

  mbox_stack_server u_dut (
    .clk(clk), .rst(rst), .cli_we(cli_we), .cli_idx(cli_idx),
    .cli_wdata(cli_wdata), .ret_idx(ret_idx), .ret_rdata(ret_rdata),
    .busy(busy), .done(done), .err(err)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (!rst && done) ndone++;

  // Scratch vectors: {addr[47:40], client reg[39:36], return reg[35:32], data[31:0]}
  localparam logic [47:0] VEC [6] = '{
    {8'd0,   4'd0,  4'd5,  32'h1111_0000},
    {8'd255, 4'd14, 4'd0,  32'hFFFF_00FF},
    {8'd17,  4'd3,  4'd14, 32'h0BAD_CAFE},
    {8'd128, 4'd7,  4'd2,  32'h8000_0001},
    {8'd1,   4'd11, 4'd9,  32'h0000_0001},
    {8'd254, 4'd6,  4'd6,  32'h5A5A_A5A5}
  };

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [3:0] n,
                                     input logic [7:0] a);
    return {op, 14'b0, a, 4'b0, n};
  endfunction

  function automatic logic [31:0] tok(input int seq, input int depth,
                                      input logic e, input logic [1:0] op);
    return {8'(seq), 1'b0, 7'(depth), 7'b0, e, 6'b0, op};
  endfunction

  function automatic logic [31:0] pat(input int r, input int i);
    return 32'hC000_0000 | 32'(r << 8) | 32'(i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cli_wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cli_we = 1'b1; cli_idx = idx; cli_wdata = d;
    @(negedge clk);
    cli_we = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 1000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 completion timeout: actual 0 expected 1");
    end
  endtask

  task automatic post(input logic [31:0] cmd);
    cli_wr(4'd15, cmd);
    wait_done();
    exp_seq++;
  endtask

  task automatic rd_ret(input logic [3:0] idx, output logic [31:0] v);
    ret_idx = idx;
    @(negedge clk);
    v = ret_rdata;
  endtask

  task automatic chk_tok(input string req, input int depth, input logic e,
                         input logic [1:0] op);
    logic [31:0] v;
    chk({req, " err"}, 32'(err), 32'(e));
    rd_ret(4'd15, v);
    chk({req, " token"}, v, tok(exp_seq, depth, e, op));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int nd0;

    // ---- R10: reset state ----
    repeat (4) @(negedge clk);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 err", 32'(err), 0);
    rst = 1'b0;
    rd_ret(4'd15, v); chk("R10 ret15", v, 0);
    rd_ret(4'd0, v);  chk("R10 ret0", v, 0);

    // ---- R4/R5/R1: vector table, scratch writes then reads ----
    for (int k = 0; k < 6; k++) begin
      cli_wr(VEC[k][39:36], VEC[k][31:0]);
      post(mk(2'b10, VEC[k][39:36], VEC[k][47:40]));
      chk_tok("R4 R1 write", 0, 1'b0, 2'b10);
    end
    for (int k = 0; k < 6; k++) begin
      post(mk(2'b11, VEC[k][35:32], VEC[k][47:40]));
      chk_tok("R5 R1 read", 0, 1'b0, 2'b11);
      rd_ret(VEC[k][35:32], v);
      chk("R5 R4 scratch data", v, VEC[k][31:0]);
    end

    // ---- R11: registered return read ----
    rd_ret(4'd5, v);
    ret_idx = 4'd0;
    #1 chk("R11 old value before edge", ret_rdata, v);
    @(negedge clk);
    chk("R11 new value after edge", ret_rdata, VEC[1][31:0]);

    // ---- R2/R3: push 3, pop 2 ----
    cli_wr(4'd0, 32'hAAAA_0000);
    cli_wr(4'd1, 32'hBBBB_0001);
    cli_wr(4'd2, 32'hCCCC_0002);
    post(mk(2'b00, 4'd3, 8'd0));
    chk_tok("R2 push3", 3, 1'b0, 2'b00);
    post(mk(2'b01, 4'd2, 8'd0));
    chk_tok("R3 pop2", 1, 1'b0, 2'b01);
    rd_ret(4'd0, v); chk("R3 pop ret0 top", v, 32'hCCCC_0002);
    rd_ret(4'd1, v); chk("R3 pop ret1", v, 32'hBBBB_0001);

    // ---- R12: scratch write does not touch stack ----
    cli_wr(4'd9, 32'hDDDD_0009);
    post(mk(2'b10, 4'd9, 8'd0));
    chk_tok("R12 scratch write", 1, 1'b0, 2'b10);
    post(mk(2'b01, 4'd1, 8'd0));
    chk_tok("R12 pop1", 0, 1'b0, 2'b01);
    rd_ret(4'd0, v); chk("R12 stacked word intact", v, 32'hAAAA_0000);

    // ---- R6: underflow on empty stack ----
    post(mk(2'b01, 4'd1, 8'd0));
    chk_tok("R6 underflow", 0, 1'b1, 2'b01);
    rd_ret(4'd0, v); chk("R6 ret0 untouched", v, 32'hAAAA_0000);

    // ---- R9: zero-count push ----
    post(mk(2'b00, 4'd0, 8'd0));
    chk_tok("R9 push0", 0, 1'b0, 2'b00);

    // ---- R2/R6: fill to exactly 64, then overflow ----
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 15; i++) cli_wr(4'(i), pat(r, i));
      post(mk(2'b00, 4'd15, 8'd0));
      chk_tok("R2 push15", 15 * (r + 1), 1'b0, 2'b00);
    end
    for (int i = 0; i < 4; i++) cli_wr(4'(i), pat(4, i));
    post(mk(2'b00, 4'd4, 8'd0));
    chk_tok("R2 push to full", 64, 1'b0, 2'b00);
    post(mk(2'b00, 4'd1, 8'd0));
    chk_tok("R6 overflow", 64, 1'b1, 2'b00);
    post(mk(2'b01, 4'd1, 8'd0));
    chk_tok("R6 pop after overflow", 63, 1'b0, 2'b01);
    rd_ret(4'd0, v); chk("R6 top unchanged by overflow", v, pat(4, 3));
    post(mk(2'b01, 4'd15, 8'd0));
    chk_tok("R3 pop15", 48, 1'b0, 2'b01);
    rd_ret(4'd0, v);  chk("R3 pop15 ret0", v, pat(4, 2));
    rd_ret(4'd2, v);  chk("R3 pop15 ret2", v, pat(4, 0));
    rd_ret(4'd3, v);  chk("R3 pop15 ret3", v, pat(3, 14));
    rd_ret(4'd14, v); chk("R3 pop15 ret14", v, pat(3, 3));

    // ---- R8: post while busy is ignored ----
    nd0 = ndone;
    cli_wr(4'd15, mk(2'b00, 4'd3, 8'd0));
    chk("R1 R8 busy after post", 32'(busy), 1);
    cli_wr(4'd15, mk(2'b01, 4'd2, 8'd0));
    wait_done();
    exp_seq++;
    chk_tok("R8 running push completes", 51, 1'b0, 2'b00);
    repeat (20) @(negedge clk);
    chk("R8 single completion", 32'(ndone - nd0), 1);
    post(mk(2'b01, 4'd0, 8'd0));
    chk_tok("R8 R9 depth shows pop ignored", 51, 1'b0, 2'b01);
    rd_ret(4'd2, v2); chk("R8 ret2 untouched", v2, pat(4, 0));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule